// File: doc/BRIEF.md
# Third-Order Sinc Decimator for a One-Bit Modulator Stream

This block converts the one-bit output of a sigma-delta modulator into signed 15-bit words at a much lower rate. It is built as a cascade of three accumulating stages and three differencing stages. Together they give a cubed moving-sum response whose nulls fall on every multiple of the output word rate.

The modulator bit is qualified by a strobe, `mod_en`, which the surrounding logic pulses once every eight master clock cycles. A two-bit select picks how many modulator samples are folded into each output word: 32, 64, 128 or 256. Each setting is rescaled so that its result fills the same 15-bit word.

Changing the select, or asserting reset, restarts the filter from an empty state. No word is flagged valid until the differencing stages have seen three complete decimation periods.

Top module: `sinc3_decim`

## Requirements
- R1: A modulator bit of 1 counts as +1 and a bit of 0 counts as −1. A stream of all zeros settles to −16384 (0x4000 as a 15-bit two's-complement word) at every ratio.
- R2: A stream of all ones saturates to +16383 (0x3FFF) at every ratio and never wraps to a negative value.
- R3: The output is the full-precision sum shifted right arithmetically by 3·log2(N) − 14 bits and then clamped to the 15-bit range. As a result, a repeating ones density of 3 in 4 gives +8192 (0x2000) and a density of 1 in 4 gives −8192 (0x6000) at every ratio.
- R4: An alternating 1,0 stream produces exactly 0 at every ratio, because the response has a null at every multiple of the output rate.
- R5: `rate_sel` values 0, 1, 2 and 3 select N = 32, 64, 128 and 256 strobes per word. With one strobe every 8 clocks, valid pulses are 8·N clocks apart. `pcm_out` changes only in a cycle in which `pcm_vld` is high.
- R6: `pcm_vld` is high for exactly one clock cycle per new word.
- R7: While `rst` is high, `pcm_out` reads 0 and `pcm_vld` is low. After reset, the first valid word appears only once 3·N strobes have been taken, and that word already holds the settled value.
- R8: A change on `rate_sel` clears all accumulating and differencing state in the next edge and suppresses `pcm_vld`. The priming period of R7 then starts again, measured at the new ratio.
- R9: The modulator bit is sampled only in cycles with `mod_en` high. Its value in other cycles has no effect on any output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Modulator sample strobe, one cycle in eight |
| mod_bit | input | 1 | One-bit modulator output |
| rate_sel | input | 2 | Decimation select: 0→32, 1→64, 2→128, 3→256 |
| pcm_out | output | 15 | Signed decimated word |
| pcm_vld | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench drives full-scale streams of both signs at every ratio. A design that dropped the clamp would wrap the positive full-scale case to a large negative word, and one with a wrong shift would scale the 3/4 and 1/4 density cases away from ±8192. The alternating stream targets the null and shows up any comb delay that is not exactly one decimated sample.

The bench measures the spacing between valid pulses and the delay from reset, or from a mid-run rate change, to the first valid word. It does this to catch a wrong terminal count, a priming count that is short by one, or state left over from the old ratio.

The bench also toggles the modulator bit in every cycle where the strobe is low. Any accumulation outside strobe cycles would then corrupt every settled value.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int ORDER    = 3;
  localparam int OUT_W    = 15;
  localparam int NMIN_LOG = 5;
  localparam int NSEL     = 4;
  localparam int SEL_W    = $clog2(NSEL);
  localparam int NMAX_LOG = NMIN_LOG + NSEL - 1;
  localparam int ACC_W    = ORDER * NMAX_LOG + 2;
  localparam int CNT_W    = NMAX_LOG;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic signed [OUT_W-1:0] pcm_t;

  function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] sel);
    logic [CNT_W:0] n;
    n = (CNT_W+1)'(1) << (NMIN_LOG + int'(sel));
    return CNT_W'(n - 1'b1);
  endfunction

  function automatic int drop_bits(input logic [SEL_W-1:0] sel);
    return ORDER * (NMIN_LOG + int'(sel)) - (OUT_W - 1);
  endfunction
endpackage

// File: rtl/sinc3_integrators.sv
module sinc3_integrators
  import sinc3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  output acc_t acc_last
);
  acc_t acc [ORDER];
  acc_t nxt [ORDER];
  acc_t step;

  assign step = bit_in ? acc_t'(1) : acc_t'(-1);

  always_comb begin
    nxt[0] = acc[0] + step;
    for (int s = 1; s < ORDER; s++) begin
      nxt[s] = acc[s] + nxt[s-1];
    end
  end

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        acc[g] <= '0;
      end else if (en) begin
        acc[g] <= nxt[g];
      end
    end
  end

  assign acc_last = acc[ORDER-1];
endmodule

// File: rtl/sinc3_decim_ctrl.sv
module sinc3_decim_ctrl
  import sinc3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == last_count(sel));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= en && at_end;
      if (en) begin
        cnt <= at_end ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sinc3_combs.sv
module sinc3_combs
  import sinc3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  acc_t acc_in,
  output acc_t diff_out
);
  acc_t dly [ORDER];
  acc_t dif [ORDER];

  always_comb begin
    dif[0] = acc_in - dly[0];
    for (int s = 1; s < ORDER; s++) begin
      dif[s] = dif[s-1] - dly[s];
    end
  end

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        dly[g] <= '0;
      end else if (tick) begin
        dly[g] <= (g == 0) ? acc_in : dif[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign diff_out = dif[ORDER-1];
endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale
  import sinc3_pkg::*;
(
  input  acc_t             full_in,
  input  logic [SEL_W-1:0] sel,
  output pcm_t             word_out
);
  localparam acc_t SAT_HI = acc_t'((1 << (OUT_W - 1)) - 1);
  localparam acc_t SAT_LO = acc_t'(-(1 << (OUT_W - 1)));

  acc_t shifted;

  always_comb begin
    shifted = full_in >>> drop_bits(sel);
    if (shifted > SAT_HI) begin
      word_out = pcm_t'(SAT_HI);
    end else if (shifted < SAT_LO) begin
      word_out = pcm_t'(SAT_LO);
    end else begin
      word_out = pcm_t'(shifted);
    end
  end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_en,
  input  logic             mod_bit,
  input  logic [SEL_W-1:0] rate_sel,
  output logic [OUT_W-1:0] pcm_out,
  output logic             pcm_vld
);
  localparam int PRIME_W = $clog2(ORDER);

  logic [SEL_W-1:0]   rate_q;
  logic               clr;
  logic               tick;
  acc_t               acc3;
  acc_t               diff3;
  pcm_t               word;
  logic [PRIME_W-1:0] primed;

  assign clr = (rate_sel != rate_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= rate_sel;
    end else begin
      rate_q <= rate_sel;
    end
  end

  sinc3_integrators u_integ (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .en      (mod_en),
    .bit_in  (mod_bit),
    .acc_last(acc3)
  );

  sinc3_decim_ctrl u_ctrl (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .en  (mod_en),
    .sel (rate_q),
    .tick(tick)
  );

  sinc3_combs u_comb (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .tick    (tick),
    .acc_in  (acc3),
    .diff_out(diff3)
  );

  sinc3_scale u_scale (
    .full_in (diff3),
    .sel     (rate_q),
    .word_out(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_out <= '0;
      pcm_vld <= 1'b0;
      primed  <= '0;
    end else if (clr) begin
      pcm_vld <= 1'b0;
      primed  <= '0;
    end else begin
      pcm_vld <= 1'b0;
      if (tick) begin
        if (primed == PRIME_W'(ORDER - 1)) begin
          pcm_out <= word;
          pcm_vld <= 1'b1;
        end else begin
          primed <= primed + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sinc3_decim_checker.sv
module sinc3_decim_checker
  import sinc3_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             mod_en,
  input logic             clr,
  input acc_t             acc_top,
  input logic [OUT_W-1:0] pcm_out,
  input logic             pcm_vld
);
  // R6
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    pcm_vld |=> !pcm_vld);

  // R7
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!pcm_vld && pcm_out == '0));

  // R8
  rate_flush_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_top == '0 && !pcm_vld));

  // R9
  strobe_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!mod_en && !clr) |=> $stable(acc_top));

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pcm_vld && !$past(rst)) |-> $stable(pcm_out));
endmodule

bind sinc3_decim sinc3_decim_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .mod_en (mod_en),
  .clr    (clr),
  .acc_top(acc3),
  .pcm_out(pcm_out),
  .pcm_vld(pcm_vld)
);

// File: tb/sinc3_decim_test.sv
module sinc3_decim_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_en = 1'b0;
  logic        mod_bit = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic [14:0] pcm_out;
  logic        pcm_vld;

  int checks = 0;
  int errors = 0;
  int pat = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sinc3_decim uut (
    .clk     (clk),
    .rst     (rst),
    .mod_en  (mod_en),
    .mod_bit (mod_bit),
    .rate_sel(rate_sel),
    .pcm_out (pcm_out),
    .pcm_vld (pcm_vld)
  );

  // {rate, pattern, expected word}
  // patterns: 0 ones, 1 zeros, 2 alternating, 3 density 3/4, 4 density 1/4
  localparam bit [19:0] VECS [11] = '{
    {2'd0, 3'd0, 15'h3FFF}, {2'd1, 3'd1, 15'h4000}, {2'd2, 3'd2, 15'h0000},
    {2'd3, 3'd0, 15'h3FFF}, {2'd0, 3'd3, 15'h2000}, {2'd1, 3'd4, 15'h6000},
    {2'd2, 3'd3, 15'h2000}, {2'd3, 3'd4, 15'h6000}, {2'd0, 3'd1, 15'h4000},
    {2'd1, 3'd2, 15'h0000}, {2'd0, 3'd2, 15'h0000}
  };

  function automatic bit pat_bit(input int p, input int n);
    case (p)
      0: return 1'b1;
      1: return 1'b0;
      2: return n[0];
      3: return n[1:0] != 2'd0;
      default: return n[1:0] == 2'd0;
    endcase
  endfunction

  // strobe every 8 clocks; bit inverted off-strobe (R9)
  initial begin
    int sc = 0;
    int ns = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        sc = 0;
        ns = 0;
        mod_en = 1'b0;
      end else begin
        mod_en = (sc == 7);
        sc = (sc + 1) % 8;
        if (mod_en) begin
          mod_bit = pat_bit(pat, ns);
          ns++;
        end else begin
          mod_bit = ~pat_bit(pat, ns);
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // waits for the next valid pulse, returns cycles waited (or -1)
  task automatic wait_vld(input int limit, output int cyc);
    cyc = -1;
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk);
      if (pcm_vld) begin
        cyc = c;
        break;
      end
    end
  endtask

  task automatic check_first(input string req, input int n, input int cyc);
    int ok;
    ok = (cyc >= 24 * n - 8 && cyc <= 24 * n + 16) ? 1 : 0;
    check(req, ok ? 24 * n : cyc, 24 * n);
  endtask

  task automatic run_vec(input int r, input int p, input int expv);
    int n;
    int cyc;
    n = 32 << r;
    @(posedge clk); #1;
    rst = 1'b1;
    rate_sel = 2'(r);
    pat = p;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    wait_vld(24 * n + 100, cyc);
    check_first("R7 first valid delay", n, cyc);
    check("R1/R2/R3/R4 settled word", int'(pcm_out), expv);
    @(negedge clk);
    check("R6 valid width", int'(pcm_vld), 0);
    wait_vld(8 * n + 20, cyc);
    check("R5 word spacing", cyc + 1, 8 * n);
    check("R3/R4 second word", int'(pcm_out), expv);
  endtask

  initial begin
    int cyc;
    int seen;
    repeat (2) @(negedge clk);
    check("R7 reset word", int'(pcm_out), 0);
    check("R7 reset valid", int'(pcm_vld), 0);

    for (int i = 0; i < 11; i++) begin
      run_vec(int'(VECS[i][19:18]), int'(VECS[i][17:15]), int'(VECS[i][14:0]));
    end

    // R7: reset mid-run clears the outputs
    @(posedge clk); #1 rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 reset word mid-run", int'(pcm_out), 0);
    check("R7 reset valid mid-run", int'(pcm_vld), 0);

    // R8: rate change mid-run restarts priming at the new ratio
    @(posedge clk); #1;
    rate_sel = 2'd0;
    pat = 0;
    @(posedge clk); #1 rst = 1'b0;
    wait_vld(24 * 32 + 100, cyc);
    check("R2 before rate change", int'(pcm_out), 15'h3FFF);
    @(posedge clk); #1;
    rate_sel = 2'd2;
    pat = 3;
    seen = 0;
    cyc = -1;
    for (int c = 1; c <= 24 * 128 + 100; c++) begin
      @(negedge clk);
      if (pcm_vld) begin
        cyc = c;
        break;
      end
    end
    check_first("R8 restart delay", 128, cyc);
    check("R8 word after rate change", int'(pcm_out), 15'h2000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule